// File: doc/BRIEF.md
# Multiphase Fractional Edge Synthesizer

This block makes a clock from a ring of 32 equally spaced phase taps. It is modelled in a single fast tick domain whose period is one phase step, which is one oscillator period divided by 32. A free-running 5-bit phase index stands for the tap that is active in the current tick. Selecting a tap therefore becomes a compare between that index and a target tap.

A 10-bit fixed-point control word sets the output frequency. Bits [9:5] hold the integer part and bits [4:0] hold the fraction in units of 1/32 step. Each output toggle adds the word to an accumulator. The integer bits of the sum give the tap of the next toggle, and the fraction bits carry the remainder forward. The word therefore equals the wanted output period divided by two phase steps. When the fraction is nonzero, half-periods mix N and N+1 steps. Their spread is one step peak to peak and their average is exactly the word.

A new word enters through a load strobe. It is held until the next output toggle and then applied. The asynchronous active-low reset is released in step with the tick clock.

Top module: `fes_edge_synth`

## Requirements
- R1: While rst_n is low, synth_clk is low at once, without waiting for a tick. After release, the first toggle happens at tap 0. The first half-period then equals the integer part of the reset word, which is 12 steps for the default 01100.01000.
- R2: Each half-period lasts the word's integer part (bits [9:5]) in ticks, plus one tick whenever adding the 5-bit fraction (bits [4:0]) to the carried fraction reaches 32/32. For 01100.01000 after a carried fraction of 8/32, the half-periods run 12, 12, 13, 12.
- R3: The 5-bit tap sum wraps modulo 32 and the carry out of the integer field is dropped. An integer part of 31 plus a fraction carry gives a 32-tick half-period, and no half-period is longer than 32 ticks.
- R4: A word whose integer part is zero acts as integer part 1, and its fraction is kept.
- R5: ctrl_word is captured only in a tick where ctrl_load is high. The captured word sets the half-period that starts at the next toggle and stays in use until replaced. Changes on ctrl_word without ctrl_load have no effect.
- R6: If ctrl_load is high in the same tick as a toggle, that toggle still adds the previous word. The new word is added at the toggle after it.
- R7: If several loads arrive within one half-period, the last one is the word used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_tick | input | 1 | Tick clock, one period per phase step |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 10 | Control word: integer part [9:5], fraction [4:0] |
| ctrl_load | input | 1 | Strobe that captures ctrl_word |
| synth_clk | output | 1 | Synthesized clock |

## Verification
A load strobe and an output toggle can fall in the same tick. In that tick the adder must still use the old word while the new word is captured for later. The bench first observes a toggle. It then counts the known half-period in ticks and raises the strobe exactly on the tick of the next toggle. It judges the result from the measured half-periods: two intervals of the old length must come before the first interval of the new length.

// File: rtl/fes_pkg.sv
package fes_pkg;
  // default geometry: 32 taps, 1/32 step resolution
  localparam int unsigned FES_TAP_BITS    = 5;
  localparam int unsigned FES_FRAC_BITS   = 5;
  localparam int unsigned FES_SYNC_STAGES = 2;

  // which stored word feeds the adder at a toggle
  typedef enum logic {
    SRC_ACTIVE  = 1'b0,
    SRC_PENDING = 1'b1
  } word_src_e;
endpackage

// File: rtl/fes_rst_sync.sv
module fes_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/fes_phase_ctr.sv
module fes_phase_ctr #(
  parameter int unsigned TAP_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [TAP_BITS-1:0] phase_o
);
  logic [TAP_BITS-1:0] phase_q;
  logic [TAP_BITS-1:0] phase_d;

  always_comb begin
    phase_d = phase_q + TAP_BITS'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/fes_word_reg.sv
module fes_word_reg
  import fes_pkg::*;
#(
  parameter int unsigned TAP_BITS  = 5,
  parameter int unsigned FRAC_BITS = 5,
  parameter logic [TAP_BITS+FRAC_BITS-1:0] RESET_WORD = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic [TAP_BITS+FRAC_BITS-1:0] word_i,
  input  logic                          edge_i,
  output logic [TAP_BITS+FRAC_BITS-1:0] step_o
);
  localparam int unsigned WORD_BITS = TAP_BITS + FRAC_BITS;

  logic [WORD_BITS-1:0] pend_q, pend_d;
  logic [WORD_BITS-1:0] act_q,  act_d;
  logic                 vld_q,  vld_d;
  logic [WORD_BITS-1:0] pick;
  logic [TAP_BITS-1:0]  pick_int;
  word_src_e            src;

  always_comb begin
    src      = vld_q ? SRC_PENDING : SRC_ACTIVE;
    pick     = (src == SRC_PENDING) ? pend_q : act_q;
    pick_int = pick[WORD_BITS-1:FRAC_BITS];
    // integer part zero would stall the compare: promote it to one
    if (pick_int == '0) step_o = {TAP_BITS'(1), pick[FRAC_BITS-1:0]};
    else                step_o = pick;
  end

  always_comb begin
    act_d  = act_q;
    pend_d = pend_q;
    vld_d  = vld_q;
    if (edge_i) begin
      act_d = pick;
      vld_d = 1'b0;
    end
    // a strobe in the toggle tick survives for the following toggle
    if (load_i) begin
      pend_d = word_i;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= RESET_WORD;
      pend_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (edge_i) act_q <= act_d;
      if (edge_i || load_i) begin
        pend_q <= pend_d;
        vld_q  <= vld_d;
      end
    end
  end
endmodule

// File: rtl/fes_accum.sv
module fes_accum #(
  parameter int unsigned TAP_BITS  = 5,
  parameter int unsigned FRAC_BITS = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TAP_BITS-1:0]           phase_i,
  input  logic [TAP_BITS+FRAC_BITS-1:0] step_i,
  output logic                          hit_o,
  output logic                          clk_o,
  output logic [TAP_BITS-1:0]           tap_o
);
  localparam int unsigned WORD_BITS = TAP_BITS + FRAC_BITS;

  logic [WORD_BITS-1:0] acc_q, acc_d;
  logic                 out_q, out_d;
  logic                 hit;

  always_comb begin
    hit   = (phase_i == acc_q[WORD_BITS-1:FRAC_BITS]);
    // carry out of the integer field is dropped by the width
    acc_d = acc_q + step_i;
    out_d = ~out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      out_q <= 1'b0;
    end else if (hit) begin
      acc_q <= acc_d;
      out_q <= out_d;
    end
  end

  assign hit_o = hit;
  assign clk_o = out_q;
  assign tap_o = acc_q[WORD_BITS-1:FRAC_BITS];
endmodule

// File: rtl/fes_edge_synth.sv
module fes_edge_synth
  import fes_pkg::*;
#(
  parameter int unsigned TAP_BITS    = FES_TAP_BITS,
  parameter int unsigned FRAC_BITS   = FES_FRAC_BITS,
  parameter int unsigned SYNC_STAGES = FES_SYNC_STAGES,
  parameter logic [TAP_BITS+FRAC_BITS-1:0] RESET_WORD = 10'b01100_01000
) (
  input  logic                          clk_tick,
  input  logic                          rst_n,
  input  logic [TAP_BITS+FRAC_BITS-1:0] ctrl_word,
  input  logic                          ctrl_load,
  output logic                          synth_clk
);
  localparam int unsigned WORD_BITS = TAP_BITS + FRAC_BITS;

  logic                 sync_rst_n;
  logic [TAP_BITS-1:0]  phase_idx;
  logic [WORD_BITS-1:0] step_word;
  logic                 tap_hit;
  logic [TAP_BITS-1:0]  acc_tap;

  fes_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk_tick),
    .arst_n (rst_n),
    .srst_n (sync_rst_n)
  );

  fes_phase_ctr #(.TAP_BITS(TAP_BITS)) u_phase (
    .clk     (clk_tick),
    .rst_n   (sync_rst_n),
    .phase_o (phase_idx)
  );

  fes_word_reg #(
    .TAP_BITS   (TAP_BITS),
    .FRAC_BITS  (FRAC_BITS),
    .RESET_WORD (RESET_WORD)
  ) u_word (
    .clk    (clk_tick),
    .rst_n  (sync_rst_n),
    .load_i (ctrl_load),
    .word_i (ctrl_word),
    .edge_i (tap_hit),
    .step_o (step_word)
  );

  fes_accum #(
    .TAP_BITS  (TAP_BITS),
    .FRAC_BITS (FRAC_BITS)
  ) u_acc (
    .clk     (clk_tick),
    .rst_n   (sync_rst_n),
    .phase_i (phase_idx),
    .step_i  (step_word),
    .hit_o   (tap_hit),
    .clk_o   (synth_clk),
    .tap_o   (acc_tap)
  );
endmodule

// File: rtl/fes_edge_synth_chk.sv
module fes_edge_synth_chk #(
  parameter int unsigned TAP_BITS  = 5,
  parameter int unsigned FRAC_BITS = 5
) (
  input logic                          clk_tick,
  input logic                          srst_n,
  input logic                          ctrl_load,
  input logic                          synth_clk,
  input logic                          hit,
  input logic [TAP_BITS+FRAC_BITS-1:0] step,
  input logic [TAP_BITS-1:0]           acc_tap
);
  localparam int unsigned WORD_BITS = TAP_BITS + FRAC_BITS;
  localparam int unsigned GAP_MAX   = 2 ** TAP_BITS;

  logic [TAP_BITS-1:0] step_int;
  logic [TAP_BITS:0]   gap_q;
  logic                prev_q;

  assign step_int = step[WORD_BITS-1:FRAC_BITS];

  always_ff @(posedge clk_tick or negedge srst_n) begin
    if (!srst_n) begin
      gap_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= synth_clk;
      if (synth_clk != prev_q)                     gap_q <= '0;
      else if (gap_q != (TAP_BITS+1)'(GAP_MAX))    gap_q <= gap_q + 1'b1;
    end
  end

  // R1
  reset_low_chk: assert property (@(posedge clk_tick) !srst_n |-> !synth_clk);

  // R2
  toggle_on_hit_chk: assert property (@(posedge clk_tick) disable iff (!srst_n)
    hit |=> (synth_clk != $past(synth_clk)));

  // R2
  hold_off_hit_chk: assert property (@(posedge clk_tick) disable iff (!srst_n)
    !hit |=> $stable(synth_clk));

  // R3
  tap_advance_chk: assert property (@(posedge clk_tick) disable iff (!srst_n)
    hit |=> ((TAP_BITS'(acc_tap - $past(acc_tap)) == $past(step_int)) ||
             (TAP_BITS'(acc_tap - $past(acc_tap)) == TAP_BITS'($past(step_int) + 1'b1))));

  // R3
  gap_limit_chk: assert property (@(posedge clk_tick) disable iff (!srst_n)
    gap_q < (TAP_BITS+1)'(GAP_MAX));

  // R4
  step_nonzero_chk: assert property (@(posedge clk_tick) disable iff (!srst_n)
    hit |-> (step_int != '0));

  // R5
  word_hold_chk: assert property (@(posedge clk_tick) disable iff (!srst_n)
    (!ctrl_load && !hit) |=> $stable(step));
endmodule

bind fes_edge_synth fes_edge_synth_chk #(
  .TAP_BITS  (TAP_BITS),
  .FRAC_BITS (FRAC_BITS)
) u_chk (
  .clk_tick  (clk_tick),
  .srst_n    (sync_rst_n),
  .ctrl_load (ctrl_load),
  .synth_clk (synth_clk),
  .hit       (tap_hit),
  .step      (step_word),
  .acc_tap   (acc_tap)
);

// File: tb/tb_fes_edge_synth.sv
module tb_fes_edge_synth;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_TICKS = 200000;
  localparam int NVEC       = 6;

  // word, then the four half-periods after the word is first used
  // (carried fraction is 8/32, left by the reset word)
  localparam logic [33:0] VEC_TBL [NVEC] = '{
    {10'b01100_01000, 6'd12, 6'd12, 6'd13, 6'd12},
    {10'b00011_10000, 6'd3,  6'd4,  6'd3,  6'd4 },
    {10'b11111_11111, 6'd32, 6'd32, 6'd32, 6'd32},
    {10'b00000_00000, 6'd1,  6'd1,  6'd1,  6'd1 },
    {10'b00001_11000, 6'd2,  6'd1,  6'd2,  6'd2 },
    {10'b00000_10000, 6'd1,  6'd2,  6'd1,  6'd2 }
  };

  logic       clk_tick  = 1'b0;
  logic       rst_n     = 1'b1;
  logic [9:0] ctrl_word = '0;
  logic       ctrl_load = 1'b0;
  logic       synth_clk;

  int   n_checks = 0;
  int   n_errs   = 0;
  int   tick     = 0;
  int   edge_at  = 0;
  bit   edge_seen = 1'b0;
  bit   finished  = 1'b0;
  logic prev_out  = 1'b0;

  always #(CLK_PERIOD/2) clk_tick = ~clk_tick;

  fes_edge_synth dut (
    .clk_tick  (clk_tick),
    .rst_n     (rst_n),
    .ctrl_word (ctrl_word),
    .ctrl_load (ctrl_load),
    .synth_clk (synth_clk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_tick);
    tick++;
    if (synth_clk !== prev_out) begin
      prev_out  = synth_clk;
      edge_seen = 1'b1;
      edge_at   = tick;
    end
  endtask

  task automatic wait_edge(output int t);
    while (!edge_seen) step();
    edge_seen = 1'b0;
    t = edge_at;
  endtask

  task automatic load_word(input logic [9:0] w);
    ctrl_word = w;
    ctrl_load = 1'b1;
    step();
    ctrl_load = 1'b0;
  endtask

  task automatic do_reset();
    ctrl_load = 1'b0;
    rst_n = 1'b0;
    #1;
    // R1: output forced low without a tick
    check(synth_clk === 1'b0, "R1", int'(synth_clk), 0);
    prev_out  = 1'b0;
    edge_seen = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  initial begin
    int t0, t1, t2, t3, t4, t5, t6, t7, t8;
    #(CLK_PERIOD/4);
    for (int v = 0; v < NVEC; v++) begin
      int tt [0:5];
      string tag;
      tag = (v == 2) ? "R3" : ((v == 3 || v == 5) ? "R4" : "R2");
      do_reset();
      wait_edge(tt[0]);
      load_word(VEC_TBL[v][33:24]);
      for (int k = 1; k < 6; k++) wait_edge(tt[k]);
      // R1: first half-period comes from the reset word
      check(tt[1] - tt[0] == 12, "R1", tt[1] - tt[0], 12);
      for (int k = 0; k < 4; k++) begin
        int exp_gap;
        exp_gap = int'(VEC_TBL[v][23-6*k -: 6]);
        check(tt[k+2] - tt[k+1] == exp_gap, tag, tt[k+2] - tt[k+1], exp_gap);
      end
    end

    // R5 R6: strobe in the very tick of a toggle
    do_reset();
    wait_edge(t0);
    load_word(10'b00101_00000);
    wait_edge(t1);
    wait_edge(t2);
    check(t2 - t1 == 5, "R5", t2 - t1, 5);
    repeat (4) step();
    load_word(10'b00111_00000);
    wait_edge(t3);
    check(t3 - t2 == 5, "R6", t3 - t2, 5);
    wait_edge(t4);
    check(t4 - t3 == 5, "R6", t4 - t3, 5);
    wait_edge(t5);
    check(t5 - t4 == 7, "R6", t5 - t4, 7);

    // R5: word change without strobe is ignored
    ctrl_word = 10'b00011_00000;
    wait_edge(t6);
    check(t6 - t5 == 7, "R5", t6 - t5, 7);
    wait_edge(t7);
    check(t7 - t6 == 7, "R5", t7 - t6, 7);

    // R7: two strobes in one half-period, the later one wins
    load_word(10'b01001_00000);
    load_word(10'b00110_00000);
    wait_edge(t8);
    check(t8 - t7 == 7, "R7", t8 - t7, 7);
    wait_edge(t0);
    check(t0 - t8 == 6, "R7", t0 - t8, 6);
    wait_edge(t1);
    check(t1 - t0 == 6, "R7", t1 - t0, 6);

    // R1: asynchronous reset mid-run
    do_reset();
    step();
    check(synth_clk === 1'b0 || edge_seen, "R1", int'(synth_clk), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (WDOG_TICKS) @(posedge clk_tick);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", tick, 0);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule